// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Host Holding Registers

The block keeps the time of day and the calendar in packed BCD counters. A one-cycle `tick` enable advances them by one second. The counters cover seconds, minutes, hours (24-hour), day of week, date, month, a two-digit year and a century byte. Months have their proper lengths, and February gains a 29th day in years whose value is divisible by four.

A host sees the time through a byte-wide register port with a 4-bit register select. It does not read or write the counters directly. It reads and writes a set of holding registers instead. A small mode controller decides how the holding registers and the counters relate, using four states:

- **TRACK**: the holding registers follow the counters on every tick.
- **SNAPSHOT**: the holding registers are frozen for a coherent read while the counters keep running.
- **EDIT**: the holding registers are frozen and accept a new time from the host.
- **COMMIT**: a one-cycle state that copies the edited values into the counters.

The transitions are:

- From TRACK, SNAPSHOT or COMMIT, the controller goes to EDIT when the write-hold bit is set. Otherwise it goes to SNAPSHOT when the read-hold bit is set, and to TRACK when neither bit is set.
- From EDIT, the controller goes to COMMIT when the write-hold bit is cleared.

A stop bit halts all advance. A frequency-test flag is stored and read back.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, the registers read as follows: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01, year 0x00, century 0x20.
- R2: Only `host_addr[3:0]` selects a register; all higher address bits are ignored. The register offsets are:
  - 0: control
  - 1: seconds
  - 2: minutes
  - 3: hours
  - 4: day of week
  - 5: date
  - 6: month
  - 7: year
  - 8: century
- R3: Offsets 9 to 15 read 0x00 and ignore writes. The writable bits of each register are:
  - control: [7:6]
  - seconds: [7:0]
  - minutes: [7:0]
  - hours: [5:0]
  - day: [2:0]
  - date: [5:0]
  - month: [4:0]
  - year: [7:0]
  - century: [5:0]

  All other bits read 0 and ignore writes.
- R4: In TRACK, each tick that is not stopped loads the advanced count into the holding registers. The new value is readable in the cycle after the tick.
- R5: Seconds and minutes roll from 59 to 00 with a carry into the next field. Hours roll from 23 to 00 with a carry into the date.
- R6: The date rolls to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the binary value of the year is divisible by 4 and 28 days otherwise. All other months have 31 days. The day of week advances on every date increment and wraps from 07 to 01.
- R7: Month 12 rolls to 01 with a carry into the year. Year 99 rolls to 00 with a carry into the century. The century wraps from 39 to 00.
- R8: Control bit 6 (read hold) freezes the holding registers while the counters keep counting. After it clears, the next tick shows the full elapsed count.
- R9: Control bit 7 (write hold) freezes the holding registers against refresh, and host writes to them stick. Clearing it copies the holding registers into the counters in the following cycle, and later ticks count from the written time.
- R10: Seconds bit 7 (stop) reads back as written. While it is 1, ticks leave the counters unchanged.
- R11: Minutes bit 7 (frequency test) reads back as written. It survives refreshes and does not affect counting.
- R12: When both hold bits are set, write hold governs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| host_addr | input | HOST_ADDR_W | Host address; the low 4 bits select the register |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data of the selected register, combinational |

## Verification
The bench builds the block with a 12-bit host address, so that reads and writes through addresses with non-zero upper bits show that only the low nibble decodes. It keeps the century limit at its default of 39, which makes the century wrap reachable in a single tick from a loaded 39/99-12-31 23:59:59. Loaded times just before month, leap-February, year and century boundaries reach every carry path in one or two ticks. Freeze, commit and stop sequences are interleaved with ticks, so the holding-register and counter paths diverge and then reconverge.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 4;

    // register offsets (low address nibble)
    localparam int unsigned REG_CTRL  = 0;
    localparam int unsigned REG_SEC   = 1;
    localparam int unsigned REG_MIN   = 2;
    localparam int unsigned REG_HOUR  = 3;
    localparam int unsigned REG_DOW   = 4;
    localparam int unsigned REG_DATE  = 5;
    localparam int unsigned REG_MONTH = 6;
    localparam int unsigned REG_YEAR  = 7;
    localparam int unsigned REG_CENT  = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] cent;
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } rtc_time_t;

    typedef enum logic [1:0] {
        ST_TRACK  = 2'd0,
        ST_SNAP   = 2'd1,
        ST_EDIT   = 2'd2,
        ST_COMMIT = 2'd3
    } rtc_mode_e;

    localparam rtc_time_t RTC_RESET_TIME = '{
        cent: 8'h20, year: 8'h00, month: 8'h01, date: 8'h01,
        dow: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    // two-digit BCD increment without wrap
    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_bcd_advance.sv
module rtc_bcd_advance
    import rtc_bcd_pkg::*;
#(
    parameter logic [7:0] CENTURY_LAST = 8'h39
) (
    input  rtc_time_t cur,
    output rtc_time_t nxt
);

    logic [6:0]        year_bin;
    logic              leap;
    logic [BYTE_W-1:0] last_date;

    always_comb begin
        year_bin = 7'({3'b000, cur.year[7:4]}) * 7'd10 + 7'({3'b000, cur.year[3:0]});
        leap     = (year_bin[1:0] == 2'b00);
        unique case (cur.month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

    always_comb begin
        nxt = cur;
        if (cur.sec == 8'h59) begin
            nxt.sec = 8'h00;
            if (cur.min == 8'h59) begin
                nxt.min = 8'h00;
                if (cur.hour == 8'h23) begin
                    nxt.hour = 8'h00;
                    nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : bcd_inc(cur.dow);
                    if (cur.date == last_date) begin
                        nxt.date = 8'h01;
                        if (cur.month == 8'h12) begin
                            nxt.month = 8'h01;
                            if (cur.year == 8'h99) begin
                                nxt.year = 8'h00;
                                nxt.cent = (cur.cent == CENTURY_LAST) ? 8'h00 : bcd_inc(cur.cent);
                            end else begin
                                nxt.year = bcd_inc(cur.year);
                            end
                        end else begin
                            nxt.month = bcd_inc(cur.month);
                        end
                    end else begin
                        nxt.date = bcd_inc(cur.date);
                    end
                end else begin
                    nxt.hour = bcd_inc(cur.hour);
                end
            end else begin
                nxt.min = bcd_inc(cur.min);
            end
        end else begin
            nxt.sec = bcd_inc(cur.sec);
        end
    end

endmodule

// File: rtl/rtc_bcd_ctrl.sv
module rtc_bcd_ctrl
    import rtc_bcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wb_nxt,
    input  logic      rb_nxt,
    output rtc_mode_e mode,
    output logic      load_cnt,
    output logic      track
);

    rtc_mode_e mode_q;
    rtc_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_EDIT:  mode_d = wb_nxt ? ST_EDIT : ST_COMMIT;
            ST_TRACK,
            ST_SNAP,
            ST_COMMIT: begin
                if (wb_nxt)      mode_d = ST_EDIT;
                else if (rb_nxt) mode_d = ST_SNAP;
                else             mode_d = ST_TRACK;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= ST_TRACK;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode     = mode_q;
        load_cnt = (mode_q == ST_COMMIT);
        track    = (mode_q == ST_TRACK);
    end

endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
    import rtc_bcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  rtc_time_t         fresh,
    input  logic              refresh,
    output rtc_time_t         usr,
    output logic              wb_nxt,
    output logic              rb_nxt,
    output logic              stop,
    output logic [BYTE_W-1:0] rdata
);

    rtc_time_t usr_q;
    logic      wb_q, rb_q, stop_q, ft_q;
    logic      wr_ctrl;

    assign wr_ctrl = host_wr && (32'(sel) == REG_CTRL);
    assign wb_nxt  = wr_ctrl ? wdata[7] : wb_q;
    assign rb_nxt  = wr_ctrl ? wdata[6] : rb_q;
    assign usr     = usr_q;
    assign stop    = stop_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            usr_q  <= RTC_RESET_TIME;
            wb_q   <= 1'b0;
            rb_q   <= 1'b0;
            stop_q <= 1'b0;
            ft_q   <= 1'b0;
        end else begin
            if (refresh) usr_q <= fresh;
            if (host_wr) begin
                case (32'(sel))
                    REG_CTRL:  begin wb_q <= wdata[7]; rb_q <= wdata[6]; end
                    REG_SEC:   begin stop_q <= wdata[7]; usr_q.sec <= {1'b0, wdata[6:0]}; end
                    REG_MIN:   begin ft_q <= wdata[7]; usr_q.min <= {1'b0, wdata[6:0]}; end
                    REG_HOUR:  usr_q.hour  <= {2'b00, wdata[5:0]};
                    REG_DOW:   usr_q.dow   <= {5'b00000, wdata[2:0]};
                    REG_DATE:  usr_q.date  <= {2'b00, wdata[5:0]};
                    REG_MONTH: usr_q.month <= {3'b000, wdata[4:0]};
                    REG_YEAR:  usr_q.year  <= wdata;
                    REG_CENT:  usr_q.cent  <= {2'b00, wdata[5:0]};
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (32'(sel))
            REG_CTRL:  rdata = {wb_q, rb_q, 6'b000000};
            REG_SEC:   rdata = {stop_q, usr_q.sec[6:0]};
            REG_MIN:   rdata = {ft_q, usr_q.min[6:0]};
            REG_HOUR:  rdata = usr_q.hour;
            REG_DOW:   rdata = usr_q.dow;
            REG_DATE:  rdata = usr_q.date;
            REG_MONTH: rdata = usr_q.month;
            REG_YEAR:  rdata = usr_q.year;
            REG_CENT:  rdata = usr_q.cent;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_bcd_pkg::*;
#(
    parameter int unsigned HOST_ADDR_W  = 8,
    parameter logic [7:0]  CENTURY_LAST = 8'h39
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [HOST_ADDR_W-1:0] host_addr,
    input  logic                   host_wr,
    input  logic [BYTE_W-1:0]      host_wdata,
    output logic [BYTE_W-1:0]      host_rdata
);

    rtc_time_t cnt_q;
    rtc_time_t cnt_adv;
    rtc_time_t usr_time;
    rtc_mode_e mode;
    logic      load_cnt, track, wb_nxt, rb_nxt, stop_q, adv;

    generate
        if (HOST_ADDR_W > SEL_W) begin : g_hi_addr
            logic unused_addr_hi;
            assign unused_addr_hi = ^host_addr[HOST_ADDR_W-1:SEL_W];
        end
    endgenerate

    assign adv = tick && !stop_q;

    rtc_bcd_advance #(.CENTURY_LAST(CENTURY_LAST)) u_adv (
        .cur (cnt_q),
        .nxt (cnt_adv)
    );

    rtc_bcd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wb_nxt   (wb_nxt),
        .rb_nxt   (rb_nxt),
        .mode     (mode),
        .load_cnt (load_cnt),
        .track    (track)
    );

    rtc_bcd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (host_addr[SEL_W-1:0]),
        .host_wr (host_wr),
        .wdata   (host_wdata),
        .fresh   (cnt_adv),
        .refresh (adv && track),
        .usr     (usr_time),
        .wb_nxt  (wb_nxt),
        .rb_nxt  (rb_nxt),
        .stop    (stop_q),
        .rdata   (host_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= RTC_RESET_TIME;
        else if (load_cnt) cnt_q <= usr_time;
        else if (adv)      cnt_q <= cnt_adv;
    end

endmodule

// File: rtl/rtc_bcd_checker.sv
module rtc_bcd_checker
    import rtc_bcd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       host_wr,
    input logic [3:0] sel,
    input logic [7:0] wdata,
    input rtc_mode_e  mode,
    input rtc_time_t  cnt,
    input rtc_time_t  usr,
    input logic       stop
);

    // R10
    stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && mode != ST_COMMIT) |=> $stable(cnt));

    // R8
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_SNAP && !host_wr) |=> $stable(usr));

    // R9
    edit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_EDIT && !host_wr) |=> $stable(usr));

    // R9
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_COMMIT) |=> (cnt == $past(usr)));

    // R12
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel == 4'd0 && wdata[7]) |=> (mode == ST_EDIT));

    // R5
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stop && mode != ST_COMMIT && cnt.sec == 8'h59) |=> (cnt.sec == 8'h00));

    // R4
    track_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ST_TRACK && tick && !stop && !host_wr) |=> (usr == cnt));

endmodule

bind rtc_bcd_core rtc_bcd_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .host_wr (host_wr),
    .sel     (host_addr[3:0]),
    .wdata   (host_wdata),
    .mode    (mode),
    .cnt     (cnt_q),
    .usr     (usr_time),
    .stop    (stop_q)
);

// File: tb/rtc_bcd_core_bench.sv
module rtc_bcd_core_bench;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    wire  [7:0]    host_rdata;

    always #5 clk = ~clk;

    rtc_bcd_core #(.HOST_ADDR_W(AW), .CENTURY_LAST(8'h39)) u_rtc_bcd_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // behavioural model: index 0 sec,1 min,2 hour,3 dow,4 date,5 month,6 year,7 cent
    int c[8];
    int u[8];
    int m_wb = 0, m_rb = 0, m_stop = 0, m_ft = 0, m_st = 0;
    logic [7:0] e_cyc;

    function automatic int b2d(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] d2b(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic void adv_c();
        if (c[0] < 59) begin c[0]++; return; end
        c[0] = 0;
        if (c[1] < 59) begin c[1]++; return; end
        c[1] = 0;
        if (c[2] < 23) begin c[2]++; return; end
        c[2] = 0;
        c[3] = (c[3] == 7) ? 1 : c[3] + 1;
        if (c[4] < dim(c[5], c[6])) begin c[4]++; return; end
        c[4] = 1;
        if (c[5] < 12) begin c[5]++; return; end
        c[5] = 1;
        if (c[6] < 99) begin c[6]++; return; end
        c[6] = 0;
        c[7] = (c[7] == 39) ? 0 : c[7] + 1;
    endfunction

    function automatic logic [7:0] mread(input logic [3:0] a);
        case (a)
            4'd0: return {1'(m_wb), 1'(m_rb), 6'b0};
            4'd1: return {1'(m_stop), 7'(d2b(u[0]))};
            4'd2: return {1'(m_ft), 7'(d2b(u[1]))};
            4'd3: return d2b(u[2]);
            4'd4: return d2b(u[3]);
            4'd5: return d2b(u[4]);
            4'd6: return d2b(u[5]);
            4'd7: return d2b(u[6]);
            4'd8: return d2b(u[7]);
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c = '{0, 0, 0, 1, 1, 1, 0, 20};
            u = c;
            m_wb = 0; m_rb = 0; m_stop = 0; m_ft = 0; m_st = 0;
        end else begin
            bit advn;
            advn = tick && (m_stop == 0);
            if (m_st == 3) c = u;
            else if (advn) begin
                adv_c();
                if (m_st == 0) u = c;
            end
            if (host_wr) begin
                case (host_addr[3:0])
                    4'd0: begin m_wb = int'(host_wdata[7]); m_rb = int'(host_wdata[6]); end
                    4'd1: begin m_stop = int'(host_wdata[7]); u[0] = b2d(host_wdata & 8'h7F); end
                    4'd2: begin m_ft = int'(host_wdata[7]); u[1] = b2d(host_wdata & 8'h7F); end
                    4'd3: u[2] = b2d(host_wdata & 8'h3F);
                    4'd4: u[3] = b2d(host_wdata & 8'h07);
                    4'd5: u[4] = b2d(host_wdata & 8'h3F);
                    4'd6: u[5] = b2d(host_wdata & 8'h1F);
                    4'd7: u[6] = b2d(host_wdata);
                    4'd8: u[7] = b2d(host_wdata & 8'h3F);
                    default: ;
                endcase
            end
            if (m_st == 2 && m_wb == 0) m_st = 3;
            else if (m_wb != 0)         m_st = 2;
            else if (m_rb != 0)         m_st = 1;
            else                        m_st = 0;
        end
    end

    // per-cycle comparison of the selected register against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            e_cyc = mread(host_addr[3:0]);
            n_chk++;
            if (host_rdata !== e_cyc) begin
                n_fail++;
                $display("FAIL R2 cycle compare addr %h: actual %h expected %h",
                         host_addr, host_rdata, e_cyc);
            end
        end
    end

    task automatic wr_reg(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
        host_addr = a;
        #1;
        n_chk++;
        if (host_rdata !== e) begin
            n_fail++;
            $display("FAIL %s addr %h: actual %h expected %h", tag, a, host_rdata, e);
        end
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y, input logic [7:0] ce);
        wr_reg(12'h000, 8'h80);
        wr_reg(12'h001, s);
        wr_reg(12'h002, mi);
        wr_reg(12'h003, h);
        wr_reg(12'h004, dw);
        wr_reg(12'h005, dt);
        wr_reg(12'h006, mo);
        wr_reg(12'h007, y);
        wr_reg(12'h008, ce);
        wr_reg(12'h000, 8'h00);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_chk(12'h000, 8'h00, "R1 ctrl");
        rd_chk(12'h001, 8'h00, "R1 sec");
        rd_chk(12'h002, 8'h00, "R1 min");
        rd_chk(12'h003, 8'h00, "R1 hour");
        rd_chk(12'h004, 8'h01, "R1 dow");
        rd_chk(12'h005, 8'h01, "R1 date");
        rd_chk(12'h006, 8'h01, "R1 month");
        rd_chk(12'h007, 8'h00, "R1 year");
        rd_chk(12'h008, 8'h20, "R1 cent");

        // R2 upper address bits ignored
        rd_chk(12'hF34, 8'h01, "R2 dow via high addr");
        rd_chk(12'h5A8, 8'h20, "R2 cent via high addr");

        // R4 tracking on tick
        pulse_tick();
        rd_chk(12'h001, 8'h01, "R4 sec after tick");
        pulse_tick();
        pulse_tick();
        rd_chk(12'h001, 8'h03, "R4 sec after three ticks");

        // R3 unused offsets and fixed-zero bits
        wr_reg(12'h009, 8'hFF);
        rd_chk(12'h009, 8'h00, "R3 offset 9");
        rd_chk(12'h00F, 8'h00, "R3 offset 15");
        wr_reg(12'h000, 8'hBF);
        rd_chk(12'h000, 8'h80, "R3 ctrl low bits");
        wr_reg(12'h005, 8'hD7);
        rd_chk(12'h005, 8'h17, "R3 date mask");
        wr_reg(12'h003, 8'hD2);
        rd_chk(12'h003, 8'h12, "R3 hour mask");
        wr_reg(12'h306, 8'hF1);
        rd_chk(12'h006, 8'h11, "R3 month mask");
        wr_reg(12'h000, 8'h00);
        @(negedge clk);

        // R5 and R6 leap February
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24, 8'h20);
        pulse_tick();
        rd_chk(12'h001, 8'h59, "R4 loaded time advances");
        pulse_tick();
        rd_chk(12'h001, 8'h00, "R5 sec wrap");
        rd_chk(12'h002, 8'h00, "R5 min wrap");
        rd_chk(12'h003, 8'h00, "R5 hour wrap");
        rd_chk(12'h005, 8'h29, "R6 leap Feb 29");
        rd_chk(12'h004, 8'h01, "R6 dow wrap");
        rd_chk(12'h006, 8'h02, "R6 month stays Feb");

        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h29, 8'h02, 8'h24, 8'h20);
        pulse_tick();
        rd_chk(12'h005, 8'h01, "R6 leap Feb end date");
        rd_chk(12'h006, 8'h03, "R6 leap Feb end month");

        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
        pulse_tick();
        rd_chk(12'h005, 8'h01, "R6 common Feb end date");
        rd_chk(12'h006, 8'h03, "R6 common Feb end month");
        rd_chk(12'h004, 8'h04, "R6 dow step");

        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h25, 8'h20);
        pulse_tick();
        rd_chk(12'h005, 8'h01, "R6 30-day month end");
        rd_chk(12'h006, 8'h05, "R6 30-day month next");

        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h25, 8'h20);
        pulse_tick();
        rd_chk(12'h005, 8'h31, "R6 31-day month day 31");

        // R7 year and century
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h39);
        pulse_tick();
        rd_chk(12'h008, 8'h00, "R7 century wrap");
        rd_chk(12'h007, 8'h00, "R7 year wrap");
        rd_chk(12'h006, 8'h01, "R7 month wrap");

        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h20);
        pulse_tick();
        rd_chk(12'h008, 8'h21, "R7 century carry");

        // R8 read hold
        set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20);
        wr_reg(12'h000, 8'h40);
        rd_chk(12'h000, 8'h40, "R8 ctrl read bit");
        pulse_tick();
        pulse_tick();
        pulse_tick();
        rd_chk(12'h001, 8'h10, "R8 frozen snapshot");
        wr_reg(12'h000, 8'h00);
        pulse_tick();
        rd_chk(12'h001, 8'h14, "R8 catch up");

        // R9 write hold
        wr_reg(12'h000, 8'h80);
        pulse_tick();
        pulse_tick();
        rd_chk(12'h001, 8'h14, "R9 frozen during edit");
        wr_reg(12'h001, 8'h30);
        rd_chk(12'h001, 8'h30, "R9 host write sticks");
        wr_reg(12'h000, 8'h00);
        @(negedge clk);
        rd_chk(12'h001, 8'h30, "R9 after commit");
        pulse_tick();
        rd_chk(12'h001, 8'h31, "R9 counts from written time");

        // R10 stop bit
        set_time(8'hA0, 8'h00, 8'h10, 8'h02, 8'h05, 8'h06, 8'h24, 8'h20);
        rd_chk(12'h001, 8'hA0, "R10 stop readback");
        pulse_tick();
        pulse_tick();
        rd_chk(12'h001, 8'hA0, "R10 stopped");
        wr_reg(12'h001, 8'h20);
        pulse_tick();
        rd_chk(12'h001, 8'h21, "R10 restart");

        // R11 frequency-test flag
        wr_reg(12'h002, 8'hC5);
        rd_chk(12'h002, 8'hC5, "R11 ftest readback");
        pulse_tick();
        rd_chk(12'h002, 8'h80, "R11 ftest survives refresh");
        rd_chk(12'h001, 8'h22, "R11 counting unaffected");
        wr_reg(12'h002, 8'h00);

        // R12 write hold wins over read hold
        wr_reg(12'h000, 8'hC0);
        rd_chk(12'h000, 8'hC0, "R12 both bits");
        wr_reg(12'h001, 8'h05);
        pulse_tick();
        rd_chk(12'h001, 8'h05, "R12 edit governs");
        wr_reg(12'h000, 8'h40);
        pulse_tick();
        rd_chk(12'h001, 8'h05, "R12 snapshot after commit");
        wr_reg(12'h000, 8'h00);
        pulse_tick();
        rd_chk(12'h001, 8'h07, "R12 committed value counted");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule